// File: doc/BRIEF.md
# Block Read Payload Receiver

This block handles the data phase of a long read over a byte-serial link. It starts once the command echo and the state byte have been checked. A host-side controller pulses `start` with three values: the number of payload bytes wanted, the number of bytes already sitting in the dummy-byte window after the data header, and whether each packet ends in a two-byte checksum. The receiver then takes bytes from the link, one byte per handshake. It hands the payload bytes to a downstream consumer, each tagged with its position in the transfer.

The transfer is split into packets of at most `PKT_BYTES` bytes:

- **First packet.** The bytes left over in the dummy window count as its opening bytes, up to the requested size. Because its header was found inside the command window, the rest of the first packet follows the window directly.
- **Later packets.** Each one is preceded by a header hunt. The receiver reads single bytes until one has an upper nibble of 0xF. A bounded number of misses is allowed.
- **Packet end.** Each packet is trailed by two checksum bytes when checksums are enabled, and by nothing when they are disabled.

The block finishes with a one-cycle `done` pulse and a status code. The code reports a clean finish, a link error, or a header hunt that gave up.

Top module: `blkrd_rx`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `out_valid` and `rx_ready` are all 0.
- R2: The first `win_len` link bytes of a transfer are window bytes. The first min(`win_len`, `req_size`) of them are delivered as payload. Any window bytes beyond the requested size are consumed and dropped.
- R3: After the window, the first packet continues with no header byte. It holds min(remaining, `PKT_BYTES` minus the window bytes delivered) bytes.
- R4: Every later packet begins with a header hunt. Bytes whose upper nibble is not 0xF are discarded. The first byte whose upper nibble is 0xF starts the packet and is not delivered. That packet holds min(remaining, `PKT_BYTES`) bytes.
- R5: A header hunt allows the first attempt plus `HDR_RETRIES` retries. If all of them miss, the block ends with status 2 (RESET) and delivers no more payload.
- R6: With `crc_en`=1, two bytes after each packet are consumed and dropped. With `crc_en`=0, no bytes are skipped. `crc_en` is captured at `start`.
- R7: A link byte presented with `rx_err`=1 in any receiving phase ends the transfer with status 1 (FAIL). That byte is not delivered, and no later payload follows.
- R8: `out_idx` starts at 0 and rises by one per delivered byte. When all `req_size` bytes have been delivered, `done` pulses for one cycle with status 0 (OK). A request of size 0 with an empty window finishes at once. `done` is never high while `busy` is high.
- R9: In payload phases `rx_ready` follows `out_ready`. A byte that is held back by the consumer is neither lost nor duplicated.
- R10: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| req_size | input | CNT_W | Payload bytes requested |
| win_len | input | WIN_W | Bytes waiting in the dummy window after the header |
| crc_en | input | 1 | Two checksum bytes follow each packet |
| rx_valid | input | 1 | Link byte available |
| rx_data | input | 8 | Link byte |
| rx_err | input | 1 | Link error flag for this byte |
| rx_ready | output | 1 | Link byte taken this cycle |
| out_valid | output | 1 | Payload byte available |
| out_ready | input | 1 | Consumer accepts payload byte |
| out_data | output | 8 | Payload byte |
| out_idx | output | CNT_W | Position of the payload byte in the transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| status | output | 2 | 0 OK, 1 FAIL, 2 RESET; valid with done |

## Verification
The checks use streams built to probe one packet rule at a time:

- **Long transfer with checksums.** It crosses the first-packet boundary and two later packets, so a wrong first-packet length or a missed checksum skip shows up as shifted data.
- **Window larger than the size.** This separates dropping the extra window bytes from delivering them.
- **Header hunt with the most misses allowed, then one more.** This pins the retry bound from both sides.
- **Errors in payload, checksum and hunt bytes.** These show the transfer stops exactly at the faulty byte.

Random backpressure on both handshakes runs through every case, and a stray `start` arrives in the middle of a transfer.

// File: rtl/blkrd_pkg.sv
package blkrd_pkg;

    typedef enum logic [1:0] {
        RS_OK    = 2'd0,
        RS_FAIL  = 2'd1,
        RS_RESET = 2'd2
    } rd_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WIN,
        S_PLAN,
        S_DATA,
        S_CRC,
        S_HDR
    } rd_state_e;

    function automatic logic is_header(input logic [7:0] b);
        return b[7:4] == 4'hF;
    endfunction

endpackage

// File: rtl/blkrd_sizer.sv
module blkrd_sizer #(
    parameter int CNT_W     = 24,
    parameter int PKT_BYTES = 8192
) (
    input  logic [CNT_W-1:0] rem,
    input  logic [CNT_W-1:0] used,
    output logic [CNT_W-1:0] len
);
    localparam logic [CNT_W-1:0] PKT_V = CNT_W'(PKT_BYTES);

    logic [CNT_W-1:0] room;

    always_comb begin
        room = PKT_V - used;
        len  = (rem < room) ? rem : room;
    end
endmodule

// File: rtl/blkrd_hdr_hunt.sv
module blkrd_hdr_hunt
    import blkrd_pkg::*;
#(
    parameter int HDR_RETRIES = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       miss,
    input  logic [7:0] byte_in,
    output logic       found,
    output logic       last_try
);
    localparam int TRY_W = $clog2(HDR_RETRIES + 1);

    logic [TRY_W-1:0] tries;

    always_ff @(posedge clk) begin
        if (rst || clear) tries <= '0;
        else if (miss)    tries <= tries + 1'b1;
    end

    assign found    = is_header(byte_in);
    assign last_try = (tries == TRY_W'(HDR_RETRIES));
endmodule

// File: rtl/blkrd_rx.sv
module blkrd_rx
    import blkrd_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int WIN_W       = 5,
    parameter int PKT_BYTES   = 8192,
    parameter int HDR_RETRIES = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] req_size,
    input  logic [WIN_W-1:0] win_len,
    input  logic             crc_en,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_err,
    output logic             rx_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic [CNT_W-1:0] out_idx,
    output logic             busy,
    output logic             done,
    output logic [1:0]       status
);
    rd_state_e        st;
    logic [CNT_W-1:0] rem, cap, pkt_left, idx, len, used;
    logic [WIN_W-1:0] win_left;
    logic             first, crc_q, crc_second, done_q;
    rd_status_e       status_q;
    logic             pay_phase, rx_phase, acc, err_hit, found, last_try;

    blkrd_sizer #(.CNT_W(CNT_W), .PKT_BYTES(PKT_BYTES)) u_sizer (
        .rem(rem), .used(used), .len(len)
    );

    blkrd_hdr_hunt #(.HDR_RETRIES(HDR_RETRIES)) u_hunt (
        .clk(clk), .rst(rst), .clear(st != S_HDR),
        .miss(acc && (st == S_HDR) && !found),
        .byte_in(rx_data), .found(found), .last_try(last_try)
    );

    always_comb begin
        used      = first ? cap : '0;
        pay_phase = (st == S_DATA) || ((st == S_WIN) && (rem != '0));
        rx_phase  = (st == S_WIN) || (st == S_DATA) || (st == S_CRC) || (st == S_HDR);
        rx_ready  = pay_phase ? out_ready : rx_phase;
        acc       = rx_valid && rx_ready;
        err_hit   = rx_valid && rx_err && rx_phase;
        out_valid = rx_valid && !rx_err && pay_phase;
    end

    assign out_data = rx_data;
    assign out_idx  = idx;
    assign busy     = (st != S_IDLE);
    assign done     = done_q;
    assign status   = status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            rem        <= '0;
            cap        <= '0;
            pkt_left   <= '0;
            idx        <= '0;
            win_left   <= '0;
            first      <= 1'b0;
            crc_q      <= 1'b0;
            crc_second <= 1'b0;
            done_q     <= 1'b0;
            status_q   <= RS_OK;
        end else begin
            done_q <= 1'b0;
            if (st == S_IDLE) begin
                if (start) begin
                    rem      <= req_size;
                    cap      <= '0;
                    idx      <= '0;
                    win_left <= win_len;
                    first    <= 1'b1;
                    crc_q    <= crc_en;
                    status_q <= RS_OK;
                    st       <= (win_len == '0) ? S_PLAN : S_WIN;
                end
            end else if (err_hit) begin
                st       <= S_IDLE;
                done_q   <= 1'b1;
                status_q <= RS_FAIL;
            end else begin
                unique case (st)
                    S_WIN: if (acc) begin
                        if (rem != '0) begin
                            rem <= rem - 1'b1;
                            cap <= cap + 1'b1;
                            idx <= idx + 1'b1;
                        end
                        win_left <= win_left - 1'b1;
                        if (win_left == WIN_W'(1)) st <= S_PLAN;
                    end
                    S_PLAN: begin
                        if (rem == '0) begin
                            st       <= S_IDLE;
                            done_q   <= 1'b1;
                            status_q <= RS_OK;
                        end else if (first) begin
                            pkt_left <= len;
                            first    <= 1'b0;
                            st       <= S_DATA;
                        end else begin
                            st <= S_HDR;
                        end
                    end
                    S_DATA: if (acc) begin
                        rem      <= rem - 1'b1;
                        idx      <= idx + 1'b1;
                        pkt_left <= pkt_left - 1'b1;
                        if (pkt_left == CNT_W'(1)) begin
                            crc_second <= 1'b0;
                            st         <= crc_q ? S_CRC : S_PLAN;
                        end
                    end
                    S_CRC: if (acc) begin
                        if (crc_second) st <= S_PLAN;
                        else            crc_second <= 1'b1;
                    end
                    S_HDR: if (acc) begin
                        if (found) begin
                            pkt_left <= len;
                            st       <= S_DATA;
                        end else if (last_try) begin
                            st       <= S_IDLE;
                            done_q   <= 1'b1;
                            status_q <= RS_RESET;
                        end
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/blkrd_checker.sv
module blkrd_checker (
    input logic clk,
    input logic rst,
    input logic rx_valid,
    input logic rx_err,
    input logic rx_ready,
    input logic out_valid,
    input logic out_ready,
    input logic busy,
    input logic done
);
    // R1: reset leaves the block idle
    assert_idle_after_reset_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !out_valid && !rx_ready));

    // R7: a flagged byte is never passed on
    assert_no_err_payload_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !rx_err);

    // R9: payload only from a present link byte
    assert_payload_from_link_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> rx_valid);

    // R9: a stalled payload byte is not taken from the link
    assert_stall_holds_link_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !rx_ready);

    // R8: done is a single-cycle pulse outside busy
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind blkrd_rx blkrd_checker u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_err(rx_err),
    .rx_ready(rx_ready), .out_valid(out_valid), .out_ready(out_ready),
    .busy(busy), .done(done)
);

// File: tb/blkrd_rx_bench.sv
module blkrd_rx_bench;
    localparam int CNT_W = 24;
    localparam int WIN_W = 5;
    localparam int PKT   = 16;
    localparam int RETR  = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [CNT_W-1:0] req_size = '0;
    logic [WIN_W-1:0] win_len = '0;
    logic             crc_en = 1'b0;
    logic             rx_valid = 1'b0;
    logic [7:0]       rx_data = '0;
    logic             rx_err = 1'b0;
    logic             rx_ready;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [7:0]       out_data;
    logic [CNT_W-1:0] out_idx;
    logic             busy;
    logic             done;
    logic [1:0]       status;

    always #10 clk = ~clk;

    blkrd_rx #(.CNT_W(CNT_W), .WIN_W(WIN_W), .PKT_BYTES(PKT), .HDR_RETRIES(RETR)) u_blkrd_rx (
        .clk(clk), .rst(rst), .start(start), .req_size(req_size), .win_len(win_len),
        .crc_en(crc_en), .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
        .rx_ready(rx_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_idx(out_idx), .busy(busy), .done(done), .status(status)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    logic [7:0] q[$];
    bit         qe[$];
    logic [7:0] ex[$];
    int         ex_pos[$];
    int         ex_stat;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic void put(input logic [7:0] b, input bit pay);
        q.push_back(b);
        qe.push_back(1'b0);
        if (pay) begin
            ex.push_back(b);
            ex_pos.push_back(q.size() - 1);
        end
    endfunction

    // Expected stream and payload from the packet rules R2..R7
    function automatic void build(input int size, input int win, input bit crc,
                                  input int garb, input int errpos);
        int rem, cap, n;
        bit first;
        logic [7:0] keep[$];
        q.delete(); qe.delete(); ex.delete(); ex_pos.delete();
        ex_stat = 0;
        rem = size; cap = 0; first = 1;
        for (int i = 0; i < win; i++) begin
            if (rem > 0) begin put(8'(i * 13 + 1), 1); rem--; cap++; end
            else put(8'h77, 0);
        end
        while (rem > 0) begin
            if (!first) begin
                for (int g = 0; g < garb; g++) put(8'h5A, 0);
                if (garb > RETR) begin ex_stat = 2; break; end
                put(8'hF1, 0);
            end
            n = first ? ((rem < PKT - cap) ? rem : PKT - cap) : ((rem < PKT) ? rem : PKT);
            for (int k = 0; k < n; k++) put(8'(q.size() * 7 + 3), 1);
            rem -= n;
            if (crc) begin put(8'hA5, 0); put(8'hC3, 0); end
            first = 0;
        end
        if (errpos >= 0 && errpos < q.size()) begin
            qe[errpos] = 1'b1;
            keep.delete();
            foreach (ex[i]) if (ex_pos[i] < errpos) keep.push_back(ex[i]);
            ex = keep;
            ex_stat = 1;
        end
    endfunction

    task automatic run(input string req, input int size, input int win, input bit crc,
                       input int garb, input int errpos, input bit poke);
        int ptr, oi;
        bit seen;
        build(size, win, crc, garb, errpos);
        @(negedge clk);
        start = 1'b1; req_size = CNT_W'(size); win_len = WIN_W'(win); crc_en = crc;
        ptr = 0; oi = 0; seen = 0;
        for (int cyc = 0; cyc < 3000 && !seen; cyc++) begin
            @(negedge clk);
            start = 1'b0;
            if (poke && cyc == 6) begin  // R10: stray start while busy
                start = 1'b1; req_size = 3; win_len = 0; crc_en = 0;
            end
            rx_valid = (ptr < q.size()) && ($urandom % 4 != 0);
            rx_data  = (ptr < q.size()) ? q[ptr] : 8'h00;
            rx_err   = (ptr < q.size()) ? qe[ptr] : 1'b0;
            out_ready = ($urandom % 3 != 0);
            #8;
            if (out_valid && out_ready) begin
                if (oi < ex.size()) begin
                    chk(out_data == ex[oi], {req, " data"}, out_data, ex[oi]);
                    chk(out_idx == CNT_W'(oi), "R8 index", out_idx, oi);
                end else chk(0, {req, " extra payload"}, oi, ex.size());
                oi++;
            end
            if (out_valid && !out_ready) chk(!rx_ready, "R9 stall", rx_ready, 0);
            if (rx_valid && rx_err) ptr = q.size();
            else if (rx_valid && rx_ready) ptr++;
            if (done) begin
                seen = 1;
                chk(status == 2'(ex_stat), {req, " status"}, status, ex_stat);
                chk(oi == ex.size(), {req, " byte count"}, oi, ex.size());
                chk(!busy, "R8 idle at done", busy, 0);
            end
        end
        chk(seen, {req, " done seen"}, seen, 1);
        rx_valid = 1'b0; rx_err = 1'b0; start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        chk(0, "watchdog", 0, 1);
        if (!finished) begin
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #8;
        chk(!busy && !done && !out_valid && !rx_ready, "R1 reset idle",
            {busy, done, out_valid, rx_ready}, 0);
        @(negedge clk);
        rst = 1'b0;
        run("R3 R4 R6 long crc", 40, 3, 1, 0, -1, 1);
        run("R2 window over size", 5, 8, 0, 0, -1, 0);
        run("R8 empty request", 0, 0, 0, 0, -1, 0);
        run("R4 hunt at limit", 37, 0, 0, RETR, -1, 0);
        run("R5 hunt exhausted", 30, 2, 1, RETR + 1, -1, 0);
        run("R7 payload error", 30, 2, 1, 2, 10, 0);
        run("R7 crc error", 30, 2, 1, 2, 17, 0);
        run("R7 header error", 30, 2, 1, 2, 19, 0);
        run("R6 no crc multi", 33, 4, 0, 1, -1, 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule